// File: doc/BRIEF.md
# Field-Programmable Logic Array Core

A parameterised programmable logic array with N_IN inputs, N_PT product terms and N_OUT outputs. Every input is split into a true and a complemented literal. Each product term is the AND of the literals whose link is intact. Each output is the OR of the product terms whose link is intact, and then passes through an XOR stage whose polarity link picks the true or the inverted function. All link states sit in one configuration register. The fuse map arrives already reduced to product terms; the block does no minimisation.

The configuration is loaded through a one-bit serial chain, one bit per clock while `prog_en_i` is high. An erase strobe returns every link to the intact state in a single cycle, and the array can then be loaded again. Outside programming the outputs follow the inputs combinationally. The default size is 3 inputs, 4 terms and 2 outputs, which gives a 34-bit chain.

Top module: `fpla_core`

## Requirements
- R1: A link bit of 1 means intact and 0 means blown. Asynchronous reset sets every link to intact, so every output reads 0 during and after reset until the array is loaded.
- R2: Chain bit `t*2*N_IN + 2*i` is the true-literal link of input i in term t, and bit `t*2*N_IN + 2*i + 1` is its complement link. A term is the AND of all its intact literals, and a term with no intact literal is 1.
- R3: A term that has both the true and the complement link of any one input intact evaluates to 0 for every input value.
- R4: Chain bit `N_PT*2*N_IN + t*N_OUT + o` is the link from term t to output o. Output o is the OR of the terms whose link is intact.
- R5: Chain bit `N_PT*2*N_IN + N_PT*N_OUT + o` is the polarity link of output o. When intact it passes the sum unchanged, and when blown it inverts the sum.
- R6: On each rising clock edge with `prog_en_i` high and `erase_i` low, `prog_data_i` enters the top of the chain and every other bit moves down one place. Sending the chain bits in index order from 0 to CFG_LEN-1 places bit 0 at the bottom.
- R7: All outputs are 0 while `prog_en_i` is high.
- R8: A rising edge with `erase_i` high sets every link to intact, even when `prog_en_i` is also high. Afterwards every output is 0.
- R9: While `prog_en_i` and `erase_i` are low, the configuration holds regardless of `prog_data_i`, and the outputs depend on `in_i` alone, in the same cycle.
- R10: After an erase, a new map can be loaded, and the outputs follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Programming clock |
| rst_ni | input | 1 | Active-low asynchronous reset (all links intact) |
| prog_en_i | input | 1 | Shift enable for the configuration chain; forces the outputs to 0 |
| prog_data_i | input | 1 | Serial configuration bit |
| erase_i | input | 1 | Restore every link to intact |
| in_i | input | N_IN | Logic inputs |
| out_o | output | N_OUT | Sum-of-products outputs after polarity |

## Verification
One loaded map holds overlapping terms and an inverted output, and the bench checks all 2^N_IN input values against truth tables that were worked out by hand. A swap of the true and complement literal order, or a misplaced OR or polarity field, shows up as wrong minterms. A second map holds a term that uses both literals of one input, and an output that is the inverse of a single literal. A design that treats contradictory literals as don't-care would show ones on the first output. The bench also asserts erase together with programming, and toggles the serial data while the shift enable is off. A design that gives the shift priority, or that shifts without the enable, would leave non-zero outputs or a corrupted map.

// File: rtl/fpla_pkg.sv
package fpla_pkg;
  function automatic int unsigned and_bits(int unsigned n_in, int unsigned n_pt);
    return n_pt * 2 * n_in;
  endfunction

  function automatic int unsigned or_bits(int unsigned n_pt, int unsigned n_out);
    return n_pt * n_out;
  endfunction

  function automatic int unsigned chain_len(int unsigned n_in, int unsigned n_pt,
                                            int unsigned n_out);
    return and_bits(n_in, n_pt) + or_bits(n_pt, n_out) + n_out;
  endfunction
endpackage

// File: rtl/fpla_cfg_chain.sv
module fpla_cfg_chain #(
  parameter int unsigned LEN = 34
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_i,
  input  logic           erase_i,
  input  logic           din_i,
  output logic [LEN-1:0] cfg_o
);
  logic [LEN-1:0] q;

  // erase wins over shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '1;
    else if (erase_i) q <= '1;
    else if (shift_i) q <= {din_i, q[LEN-1:1]};
  end

  assign cfg_o = q;
endmodule

// File: rtl/fpla_and_plane.sv
module fpla_and_plane #(
  parameter int unsigned N_IN = 3,
  parameter int unsigned N_PT = 4
) (
  input  logic [N_IN-1:0]        in_i,
  input  logic [N_PT*2*N_IN-1:0] fuse_i,
  output logic [N_PT-1:0]        term_o
);
  localparam int unsigned ROW = 2 * N_IN;

  logic [ROW-1:0] lits;

  // even slot: true literal, odd slot: complement
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = in_i[i];
    assign lits[2*i+1] = ~in_i[i];
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign term_o[t] = &(lits | ~fuse_i[t*ROW +: ROW]);
  end
endmodule

// File: rtl/fpla_or_plane.sv
module fpla_or_plane #(
  parameter int unsigned N_PT  = 4,
  parameter int unsigned N_OUT = 2
) (
  input  logic [N_PT-1:0]       term_i,
  input  logic [N_PT*N_OUT-1:0] or_fuse_i,
  input  logic [N_OUT-1:0]      pol_fuse_i,
  input  logic                  force_zero_i,
  output logic [N_OUT-1:0]      out_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_PT-1:0] col;
    logic            sum;

    for (genvar t = 0; t < N_PT; t++) begin : g_col
      assign col[t] = or_fuse_i[t*N_OUT + o];
    end

    assign sum      = |(term_i & col);
    // intact polarity link feeds 0 into the XOR
    assign out_o[o] = force_zero_i ? 1'b0 : (sum ^ ~pol_fuse_i[o]);
  end
endmodule

// File: rtl/fpla_core.sv
module fpla_core #(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned N_PT  = 4,
  parameter int unsigned N_OUT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_en_i,
  input  logic             prog_data_i,
  input  logic             erase_i,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] out_o
);
  localparam int unsigned AND_BITS = fpla_pkg::and_bits(N_IN, N_PT);
  localparam int unsigned OR_BITS  = fpla_pkg::or_bits(N_PT, N_OUT);
  localparam int unsigned CFG_LEN  = fpla_pkg::chain_len(N_IN, N_PT, N_OUT);

  logic [CFG_LEN-1:0] cfg_q;
  logic [N_PT-1:0]    term;

  fpla_cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (prog_en_i),
    .erase_i (erase_i),
    .din_i   (prog_data_i),
    .cfg_o   (cfg_q)
  );

  fpla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .in_i   (in_i),
    .fuse_i (cfg_q[AND_BITS-1:0]),
    .term_o (term)
  );

  fpla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .term_i       (term),
    .or_fuse_i    (cfg_q[AND_BITS +: OR_BITS]),
    .pol_fuse_i   (cfg_q[AND_BITS+OR_BITS +: N_OUT]),
    .force_zero_i (prog_en_i),
    .out_o        (out_o)
  );
endmodule

// File: rtl/fpla_core_chk.sv
module fpla_core_chk #(
  parameter int unsigned N_IN    = 3,
  parameter int unsigned N_OUT   = 2,
  parameter int unsigned CFG_LEN = 34
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               prog_en_i,
  input logic               prog_data_i,
  input logic               erase_i,
  input logic [N_IN-1:0]    in_i,
  input logic [N_OUT-1:0]   out_o,
  input logic [CFG_LEN-1:0] cfg_q
);
  assert_prog_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_en_i |-> out_o == '0);

  assert_shift_in_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en_i && !erase_i) |=> cfg_q[CFG_LEN-1] == $past(prog_data_i));

  assert_shift_move_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en_i && !erase_i) |=> cfg_q[CFG_LEN-2:0] == $past(cfg_q[CFG_LEN-1:1]));

  assert_erase_intact_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (&cfg_q));

  assert_erase_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (prog_en_i || erase_i || out_o == '0));

  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prog_en_i && !erase_i) |=> $stable(cfg_q));

  assert_out_comb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prog_en_i && !erase_i) |=> (prog_en_i || !$stable(in_i) || $stable(out_o)));
endmodule

bind fpla_core fpla_core_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .CFG_LEN(CFG_LEN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .prog_en_i   (prog_en_i),
  .prog_data_i (prog_data_i),
  .erase_i     (erase_i),
  .in_i        (in_i),
  .out_o       (out_o),
  .cfg_q       (cfg_q)
);

// File: tb/fpla_core_tb.sv
`timescale 1ns/1ps
module fpla_core_tb;
  localparam int N  = 3;
  localparam int P  = 4;
  localparam int M  = 2;
  localparam int AB = P*2*N;
  localparam int OB = P*M;
  localparam int L  = AB + OB + M;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_en = 1'b0, prog_data = 1'b0, erase = 1'b0;
  logic [N-1:0] in_v = '0;
  logic [M-1:0] out_v;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [L-1:0] map;
  logic [L-1:0] mdl;

  always #2 clk = ~clk;

  fpla_core #(.N_IN(N), .N_PT(P), .N_OUT(M)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_en_i(prog_en), .prog_data_i(prog_data),
    .erase_i(erase), .in_i(in_v), .out_o(out_v)
  );

  // behavioural reference: link list plus sum-of-products evaluation
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mdl <= '1;
    else if (erase)   mdl <= '1;
    else if (prog_en) mdl <= {prog_data, mdl[L-1:1]};
  end

  function automatic logic [M-1:0] model_eval(logic [L-1:0] c, logic [N-1:0] x);
    logic [M-1:0] r = '0;
    for (int o = 0; o < M; o++) begin
      int hits = 0;
      for (int t = 0; t < P; t++) begin
        int ok = 1;
        for (int i = 0; i < N; i++) begin
          if (c[t*2*N + 2*i] && !x[i]) ok = 0;
          if (c[t*2*N + 2*i + 1] && x[i]) ok = 0;
        end
        if (ok == 1 && c[AB + t*M + o]) hits++;
      end
      r[o] = (hits > 0) ^ !c[AB + OB + o];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [M-1:0] act, logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished)
      chk("R2_R4_R5_R7 model", out_v, prog_en ? '0 : model_eval(mdl, in_v));
  end

  task automatic lnk_and(int t, int i, int comp);
    map[t*2*N + 2*i + comp] = 1'b1;
  endtask

  task automatic lnk_or(int t, int o);
    map[AB + t*M + o] = 1'b1;
  endtask

  task automatic load_map();
    for (int k = 0; k < L; k++) begin
      prog_en = 1'b1; prog_data = map[k];
      @(negedge clk);
      chk("R7 outputs low while shifting", out_v, '0);
      @(posedge clk); #1;
    end
    prog_en = 1'b0; prog_data = 1'b0;
  endtask

  task automatic sweep(string req, logic [7:0] m0, logic [7:0] m1);
    for (int x = 0; x < (1 << N); x++) begin
      in_v = x[N-1:0];
      @(negedge clk);
      chk(req, out_v, {m1[x], m0[x]});
      @(posedge clk); #1;
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; failures++;
    $display("FAIL watchdog act=running exp=done");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset out", out_v, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    sweep("R1 intact after reset", 8'h00, 8'h00);

    // map A: f0 = m(0,1,2,5,7) true, f1 = complement of m(0,2,5,7)
    map = '0;
    lnk_and(0, 2, 1); lnk_and(0, 1, 1);
    lnk_and(1, 2, 1); lnk_and(1, 0, 1);
    lnk_and(2, 2, 0); lnk_and(2, 0, 0);
    lnk_and(3, 1, 0); lnk_and(3, 0, 1);
    lnk_or(0, 0); lnk_or(1, 0); lnk_or(2, 0);
    lnk_or(1, 1); lnk_or(2, 1);
    map[AB+OB+0] = 1'b1;
    map[AB+OB+1] = 1'b0;
    load_map();
    sweep("R2 R4 R5 R6 map A", 8'hA7, 8'h5A);

    // serial data toggling without enable must not disturb
    for (int k = 0; k < 6; k++) begin
      prog_data = k[0];
      @(posedge clk); #1;
    end
    sweep("R9 hold without enable", 8'hA7, 8'h5A);

    erase = 1'b1;
    @(posedge clk); #1;
    erase = 1'b0;
    sweep("R8 erase clears", 8'h00, 8'h00);

    // map B: term0 uses both literals of input 0 -> f0 = 0; f1 = not x1
    map = '0;
    lnk_and(0, 0, 0); lnk_and(0, 0, 1); lnk_and(0, 1, 0);
    lnk_and(1, 1, 0);
    lnk_or(0, 0); lnk_or(1, 1);
    map[AB+OB+0] = 1'b1;
    map[AB+OB+1] = 1'b0;
    load_map();
    sweep("R3 R10 map B", 8'h00, 8'h33);

    prog_en = 1'b1; erase = 1'b1; prog_data = 1'b0;
    @(posedge clk); #1;
    prog_en = 1'b0; erase = 1'b0;
    sweep("R8 erase over shift", 8'h00, 8'h00);

    report();
  end
endmodule